// File: doc/BRIEF.md
# Track Format Address-Field Decoder

This block sits beside the data output register of a single-density floppy controller and listens to the byte stream the CPU writes while a track is being formatted. In that mode each CPU byte carries interleaved clock and data bits. The block keeps only the data bits (the even positions) as one nibble per write and reassembles whole bytes two nibbles at a time. It watches for the 0xFE identification mark and then gathers the four bytes that follow.

When a gathered identification field is valid, the block raises a one-cycle format request. The request carries the track number, the sector number and the fixed filler byte 0xE5. A downstream medium writer uses these to lay down the sector. The block also owns the data-request flag, which tells the CPU that format bytes are expected. The block takes in three things: writes to the command register, writes to the data output register, and the byte written each time. Writing the physical medium is handled elsewhere.

Top module: `trkfmt_id_decoder`

## Requirements
- R1: After reset, fmt_req and data_req are 0, and fmt_track, fmt_sector and fmt_filler are all 0.
- R2: A command write whose low four bits equal 0xB sets data_req. Any other command write clears it. data_req changes only on command writes.
- R3: Data writes are accepted only while the last written command has low nibble 0xB and bit 4 set. Under any other command, no field is decoded and fmt_req stays 0.
- R4: Each accepted data write yields one nibble, taken from bits 0, 2, 4 and 6 of the written byte, which become nibble bits 0 to 3. The odd bits have no effect.
- R5: While hunting, each nibble shifts into a mark byte as the low nibble, with the previous low nibble moving to the high half. The mark is found on the write that makes this byte 0xFE, so any number of leading nibbles may come before the pair F, E.
- R6: After the mark, the next eight nibbles form four bytes in order, high nibble first: track, a first zero byte, sector and a second zero byte. If both zero bytes are 0x00, fmt_req is 1 in the cycle after the eighth write, with fmt_track = track, fmt_sector = sector and fmt_filler = 0xE5. The earlier writes give no request.
- R7: If either zero byte is nonzero, no request is made and hunting for a new mark resumes at once.
- R8: fmt_req lasts exactly one cycle. fmt_track, fmt_sector and fmt_filler keep their values until the next request.
- R9: After a request, hunting resumes without a new command, so further fields on the same track are decoded in turn.
- R10: Any command write discards a partly collected field and the partly built mark byte. Hunting restarts from an empty state.
- R11: When a command write and a data write fall in the same cycle, the command write takes effect and the data byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_val | input | 8 | Value written to the command register |
| dout_wr | input | 1 | Data output register write strobe |
| dout_val | input | 8 | Value written to the data output register |
| fmt_req | output | 1 | One-cycle format-sector request |
| fmt_track | output | 8 | Track number of the last request |
| fmt_sector | output | 8 | Sector number of the last request |
| fmt_filler | output | 8 | Filler byte of the last request |
| data_req | output | 1 | Data-request flag toward the CPU |

## Verification
A command write and a data write can land on the same clock edge, and the block must then reset its hunt and drop the byte. The bench provokes this after a lone F nibble by issuing the format command again in the same cycle as an E byte, which would complete the mark if it were accepted. It then feeds the eight nibbles of an otherwise valid field. The collision is judged correct if no format request appears and data_req is still set.

// File: rtl/trkfmt_pkg.sv
package trkfmt_pkg;
   localparam int unsigned BYTE_W        = 8;
   localparam logic [3:0]  OP_FREE_WRITE = 4'hB;
   localparam logic [7:0]  ID_MARK       = 8'hFE;
   localparam logic [7:0]  GAP_FILL      = 8'hE5;
   localparam int unsigned ID_BYTES      = 5;   // mark + track + zero + sector + zero
endpackage

// File: rtl/trkfmt_nibble_pick.sv
module trkfmt_nibble_pick #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NIB_W = BYTE_W / 2
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic [NIB_W-1:0]  nib_o
);
   if ((BYTE_W % 2) != 0 || BYTE_W < 2) begin : g_bad_width
      $error("trkfmt_nibble_pick: BYTE_W must be even and at least 2");
   end

   // data bits sit on even positions, clock bits on odd ones
   for (genvar g = 0; g < NIB_W; g++) begin : g_pick
      assign nib_o[g] = byte_i[2*g];
   end
endmodule

// File: rtl/trkfmt_field_hunt.sv
module trkfmt_field_hunt #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned FIELD_BYTES = 5,
   parameter logic [BYTE_W-1:0] MARK  = 8'hFE,
   parameter int unsigned TRK_POS     = 1,
   parameter int unsigned ZA_POS      = 2,
   parameter int unsigned SEC_POS     = 3,
   parameter int unsigned ZB_POS      = 4,
   localparam int unsigned NIB_W      = BYTE_W / 2,
   localparam int unsigned LAST_IDX   = 2 * FIELD_BYTES - 1,
   localparam int unsigned IDX_W      = $clog2(LAST_IDX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [NIB_W-1:0]  nib_i,
   output logic              hit_o,
   output logic [BYTE_W-1:0] track_o,
   output logic [BYTE_W-1:0] sector_o
);
   if (FIELD_BYTES < 2) begin : g_bad_len
      $error("trkfmt_field_hunt: FIELD_BYTES must be at least 2");
   end
   if (TRK_POS == 0 || TRK_POS >= FIELD_BYTES || SEC_POS == 0 || SEC_POS >= FIELD_BYTES ||
       ZA_POS == 0 || ZA_POS >= FIELD_BYTES || ZB_POS == 0 || ZB_POS >= FIELD_BYTES) begin : g_bad_pos
      $error("trkfmt_field_hunt: field positions must lie after the mark byte");
   end

   logic [FIELD_BYTES-1:0][BYTE_W-1:0] buf_q, buf_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic             hit;

   always_comb begin
      buf_n = buf_q;
      idx_n = idx_q;
      hit   = 1'b0;
      if (clr_i) begin
         buf_n = '0;
         idx_n = '0;
      end else if (wr_i) begin
         for (int b = 0; b < FIELD_BYTES; b++) begin
            if ((idx_q >> 1) == IDX_W'(b)) begin
               buf_n[b] = {buf_q[b][NIB_W-1:0], nib_i};
            end
         end
         if (idx_q == '0) begin
            if (buf_n[0] == MARK) idx_n = IDX_W'(2);
         end else if (idx_q == IDX_W'(LAST_IDX)) begin
            idx_n = '0;
            hit   = (buf_n[ZA_POS] == '0) && (buf_n[ZB_POS] == '0);
         end else begin
            idx_n = idx_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         idx_q <= '0;
      end else begin
         buf_q <= buf_n;
         idx_q <= idx_n;
      end
   end

   assign hit_o    = hit;
   assign track_o  = buf_n[TRK_POS];
   assign sector_o = buf_n[SEC_POS];

   // R10
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (idx_q == '0));
   // R9
   hunt_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> (idx_q == '0));
endmodule

// File: rtl/trkfmt_id_decoder.sv
module trkfmt_id_decoder
   import trkfmt_pkg::*;
#(
   parameter int unsigned BYTE_W       = trkfmt_pkg::BYTE_W,
   parameter logic [3:0]  FMT_OP       = OP_FREE_WRITE,
   parameter int unsigned FMT_FLAG_BIT = 4,
   parameter logic [BYTE_W-1:0] MARK   = ID_MARK,
   parameter logic [BYTE_W-1:0] FILLER = GAP_FILL,
   localparam int unsigned NIB_W       = BYTE_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [BYTE_W-1:0] cmd_val,
   input  logic              dout_wr,
   input  logic [BYTE_W-1:0] dout_val,
   output logic              fmt_req,
   output logic [BYTE_W-1:0] fmt_track,
   output logic [BYTE_W-1:0] fmt_sector,
   output logic [BYTE_W-1:0] fmt_filler,
   output logic              data_req
);
   if (FMT_FLAG_BIT < 4 || FMT_FLAG_BIT >= BYTE_W) begin : g_bad_flag
      $error("trkfmt_id_decoder: format flag must sit above the opcode nibble");
   end

   logic [BYTE_W-1:0] cmd_q;
   logic              fmt_on;
   logic              take;
   logic [NIB_W-1:0]  nib;
   logic              hit;
   logic [BYTE_W-1:0] trk_n, sec_n;

   assign fmt_on = (cmd_q[3:0] == FMT_OP) && cmd_q[FMT_FLAG_BIT];
   assign take   = dout_wr && !cmd_wr && fmt_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         data_req <= 1'b0;
      end else if (cmd_wr) begin
         cmd_q    <= cmd_val;
         data_req <= (cmd_val[3:0] == FMT_OP);
      end
   end

   trkfmt_nibble_pick #(.BYTE_W(BYTE_W)) pick_i (
      .byte_i (dout_val),
      .nib_o  (nib)
   );

   trkfmt_field_hunt #(
      .BYTE_W      (BYTE_W),
      .FIELD_BYTES (ID_BYTES),
      .MARK        (MARK)
   ) hunt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (cmd_wr),
      .wr_i     (take),
      .nib_i    (nib),
      .hit_o    (hit),
      .track_o  (trk_n),
      .sector_o (sec_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_req    <= 1'b0;
         fmt_track  <= '0;
         fmt_sector <= '0;
         fmt_filler <= '0;
      end else begin
         fmt_req <= hit;
         if (hit) begin
            fmt_track  <= trk_n;
            fmt_sector <= sec_n;
            fmt_filler <= FILLER;
         end
      end
   end

   // R8
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_req |=> !fmt_req);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fmt_req |-> ($stable(fmt_track) && $stable(fmt_sector) && $stable(fmt_filler)));
   // R11
   cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_wr || cmd_wr) |=> !fmt_req);
   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fmt_on |=> !fmt_req);
   // R2
   dreq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(data_req));
endmodule

// File: tb/trkfmt_id_decoder_tb_top.sv
`timescale 1ns/1ps
module trkfmt_id_decoder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [7:0] cmd_val = '0;
   logic       dout_wr = 1'b0;
   logic [7:0] dout_val = '0;
   logic       fmt_req;
   logic [7:0] fmt_track, fmt_sector, fmt_filler;
   logic       data_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   trkfmt_id_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(cmd_val),
      .dout_wr(dout_wr), .dout_val(dout_val), .fmt_req(fmt_req),
      .fmt_track(fmt_track), .fmt_sector(fmt_sector), .fmt_filler(fmt_filler),
      .data_req(data_req)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] spread(input logic [3:0] n, input logic [7:0] odd);
      return {odd[7], n[3], odd[5], n[2], odd[3], n[1], odd[1], n[0]};
   endfunction

   task automatic cmd_write(input logic [7:0] v);
      @(negedge clk); cmd_wr = 1'b1; cmd_val = v;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic send_nib(input logic [3:0] n, input logic [7:0] odd);
      @(negedge clk); dout_wr = 1'b1; dout_val = spread(n, odd);
      @(negedge clk); dout_wr = 1'b0;
   endtask

   // mark then eight field nibbles; fmt_req checked low after all but the last
   task automatic send_field(input logic [7:0] trk, input logic [7:0] za,
                             input logic [7:0] sec, input logic [7:0] zb,
                             input logic [7:0] odd, input string req);
      logic [3:0] seq [10];
      seq = '{4'hF, 4'hE, trk[7:4], trk[3:0], za[7:4], za[3:0],
              sec[7:4], sec[3:0], zb[7:4], zb[3:0]};
      for (int i = 0; i < 10; i++) begin
         send_nib(seq[i], odd);
         if (i < 9) chk({req, " early"}, {7'd0, fmt_req}, 8'd0);
      end
   endtask

   task automatic t_reset();
      chk("R1 fmt_req", {7'd0, fmt_req}, 8'd0);
      chk("R1 data_req", {7'd0, data_req}, 8'd0);
      chk("R1 track", fmt_track, 8'h00);
      chk("R1 sector", fmt_sector, 8'h00);
      chk("R1 filler", fmt_filler, 8'h00);
   endtask

   task automatic t_data_req();
      cmd_write(8'h1B); chk("R2 set", {7'd0, data_req}, 8'd1);
      cmd_write(8'h10); chk("R2 clear", {7'd0, data_req}, 8'd0);
      cmd_write(8'h0B); chk("R2 set no flag", {7'd0, data_req}, 8'd1);
      send_nib(4'h5, 8'h00);
      chk("R2 stable on data write", {7'd0, data_req}, 8'd1);
   endtask

   task automatic t_basic();
      cmd_write(8'h1B);
      send_field(8'h27, 8'h00, 8'h0C, 8'h00, 8'hAA, "R6");
      chk("R6 pulse", {7'd0, fmt_req}, 8'd1);
      chk("R6 track", fmt_track, 8'h27);
      chk("R6 sector", fmt_sector, 8'h0C);
      chk("R6 filler", fmt_filler, 8'hE5);
      @(negedge clk);
      chk("R8 one cycle", {7'd0, fmt_req}, 8'd0);
      chk("R8 track hold", fmt_track, 8'h27);
   endtask

   task automatic t_hunt_next();
      // R5: junk nibbles before the mark; R4: odd bits clear this time; R9: no new command
      send_nib(4'h3, 8'h00);
      send_nib(4'hF, 8'h00);
      send_field(8'h5A, 8'h00, 8'h13, 8'h00, 8'h00, "R5");
      chk("R9 pulse", {7'd0, fmt_req}, 8'd1);
      chk("R4 track", fmt_track, 8'h5A);
      chk("R4 sector", fmt_sector, 8'h13);
   endtask

   task automatic t_invalid();
      send_field(8'h11, 8'h01, 8'h02, 8'h00, 8'hFF, "R7");
      chk("R7 no pulse za", {7'd0, fmt_req}, 8'd0);
      chk("R8 hold after bad", fmt_track, 8'h5A);
      send_field(8'h11, 8'h00, 8'h02, 8'h40, 8'h55, "R7");
      chk("R7 no pulse zb", {7'd0, fmt_req}, 8'd0);
      send_field(8'h4C, 8'h00, 8'h1A, 8'h00, 8'h55, "R7");
      chk("R7 resume pulse", {7'd0, fmt_req}, 8'd1);
      chk("R7 resume track", fmt_track, 8'h4C);
      chk("R7 resume sector", fmt_sector, 8'h1A);
   endtask

   task automatic t_inactive();
      cmd_write(8'h0B);
      send_field(8'h31, 8'h00, 8'h07, 8'h00, 8'h00, "R3");
      chk("R3 no flag", {7'd0, fmt_req}, 8'd0);
      cmd_write(8'h1A);
      send_field(8'h32, 8'h00, 8'h08, 8'h00, 8'h00, "R3");
      chk("R3 other op", {7'd0, fmt_req}, 8'd0);
      chk("R3 track unchanged", fmt_track, 8'h4C);
   endtask

   task automatic t_restart();
      logic [3:0] tail [6];
      tail = '{4'h0, 4'h0, 4'h0, 4'hC, 4'h0, 4'h0};
      cmd_write(8'h1B);
      send_nib(4'hF, 8'h00); send_nib(4'hE, 8'h00);
      send_nib(4'h2, 8'h00); send_nib(4'h7, 8'h00);
      cmd_write(8'h1B);
      foreach (tail[i]) send_nib(tail[i], 8'h00);
      chk("R10 partial dropped", {7'd0, fmt_req}, 8'd0);
      send_field(8'h66, 8'h00, 8'h05, 8'h00, 8'hAA, "R10");
      chk("R10 fresh pulse", {7'd0, fmt_req}, 8'd1);
      chk("R10 fresh track", fmt_track, 8'h66);
   endtask

   task automatic t_collide();
      logic [3:0] rest [8];
      rest = '{4'h2, 4'h7, 4'h0, 4'h0, 4'h0, 4'h5, 4'h0, 4'h0};
      cmd_write(8'h1B);
      send_nib(4'hF, 8'h00);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_val = 8'h1B; dout_wr = 1'b1; dout_val = spread(4'hE, 8'h00);
      @(negedge clk);
      cmd_wr = 1'b0; dout_wr = 1'b0;
      chk("R11 data_req", {7'd0, data_req}, 8'd1);
      foreach (rest[i]) send_nib(rest[i], 8'h00);
      chk("R11 byte dropped", {7'd0, fmt_req}, 8'd0);
      chk("R11 track kept", fmt_track, 8'h66);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_req();
      t_basic();
      t_hunt_next();
      t_invalid();
      t_inactive();
      t_restart();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule